// File: doc/BRIEF.md
# Transmit Power Ramp Sequencer

This block is the control sequencer for one transmit burst. It switches the power amplifier on, asks an external ramp generator for a rising ramp, and waits out a programmable hold. It then stays in the active transmit phase for as long as the go request is held high. When go is released it asks for a falling ramp and waits a second programmable hold. Only after that second hold does it switch the amplifier off and return to rest. The ramp waveform itself is made elsewhere. This block sees only the request it issues and the done pulse it gets back.

The two holds use different time bases. Both are given as enable pulses from the surrounding clocking.

- The rising-side hold counts pulses of a slow (12 MHz) enable. It is measured from the start of the rising ramp, not from its end. If the ramp itself takes longer than the programmed hold, the hold state therefore lasts only one cycle.
- The falling-side hold counts pulses of a fast (48 MHz) enable. It starts when the falling ramp reports done.

Both hold values are 16-bit inputs. Their register copies elsewhere reset to zero, and a zero hold costs exactly one cycle. Reset is asynchronous and active low. Its release is synchronised inside the block.

Top module: `tx_ramp_seq`

## Requirements
- R1: While reset is low, and for two clock edges after it rises (synchroniser depth), the sequencer is at rest and pa_en_o, ramp_up_req_o, ramp_dn_req_o and busy_o are all 0.
- R2: When the sequencer is at rest and go_i is sampled high, pa_en_o is 1 on the next cycle with ramp_up_req_o still 0, and ramp_up_req_o is 1 on the cycle after that.
- R3: ramp_up_req_o stays 1 until ramp_up_done_i is sampled high while it is 1; it is 0 on the following cycle.
- R4: The rising hold counter is cleared on the cycle before ramp_up_req_o first rises. It counts tick_slow_i pulses during the rising ramp and the rising hold, saturating at all-ones. The hold ends on the cycle after the count is found at or above hold_up_i.
- R5: A hold value of zero (either hold) keeps the sequencer in that hold state for exactly one cycle.
- R6: In the active phase, go_i sampled low gives ramp_dn_req_o = 1 on the next cycle; while go_i stays high the active phase persists.
- R7: ramp_dn_req_o stays 1 until ramp_dn_done_i is sampled high. The falling hold counter then starts from zero and counts tick_fast_i pulses. pa_en_o stays 1 until the cycle after the count is found at or above hold_dn_i, when it and busy_o fall to 0.
- R8: go_i has no effect except at rest. Pulses or drops of go_i during ramps or holds do not restart or shorten the burst. A go_i still high on return to rest starts a new burst.
- R9: busy_o and pa_en_o are 1 in every state except rest. At most one of ramp_up_req_o and ramp_dn_req_o is 1, and either one implies busy_o.
- R10: ramp done pulses outside the matching ramp state, and tick pulses outside the matching counting states, have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Burst request (start when high at rest, end when low in active phase) |
| tick_fast_i | input | 1 | 48 MHz time-base enable for the falling hold |
| tick_slow_i | input | 1 | 12 MHz time-base enable for the rising hold |
| ramp_up_done_i | input | 1 | Rising ramp complete |
| ramp_dn_done_i | input | 1 | Falling ramp complete |
| hold_up_i | input | 16 | Rising hold length in slow ticks, from start of ramp-up |
| hold_dn_i | input | 16 | Falling hold length in fast ticks, after ramp-down |
| pa_en_o | output | 1 | Power amplifier enable |
| ramp_up_req_o | output | 1 | Request a rising ramp |
| ramp_dn_req_o | output | 1 | Request a falling ramp |
| busy_o | output | 1 | Sequencer not at rest |

## Verification
The hardest case to reach from the ports is a rising ramp that outlasts its hold. Here the hold has already elapsed when the done pulse arrives, so the hold state must last a single cycle rather than restart its count. The bench builds this case with a slow tick every fourth cycle, a short hold and a ramp responder that delays done for twenty cycles. Separate runs show that go is ignored outside rest. In one, go is dropped during the rising hold, which leads to an immediate ramp-down on reaching the active phase. In another, go is raised during the falling hold, which restarts a burst only after rest is reached. Stray done pulses are also scattered across every state.

// File: rtl/tx_ramp_pkg.sv
package tx_ramp_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_PA_ON   = 3'd1,
    S_RAMP_UP = 3'd2,
    S_HOLD_UP = 3'd3,
    S_ACTIVE  = 3'd4,
    S_RAMP_DN = 3'd5,
    S_HOLD_DN = 3'd6
  } seq_state_e;
endpackage

// File: rtl/tx_rst_sync.sv
module tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sr_q <= '0;
    else          sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sr_q[STAGES-1];
endmodule

// File: rtl/tx_hold_timer.sv
module tx_hold_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             elapsed_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                         cnt_d = '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o     = cnt_q;
  assign elapsed_o = (cnt_q >= limit_i);
endmodule

// File: rtl/tx_ramp_fsm.sv
module tx_ramp_fsm
  import tx_ramp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic       up_done_i,
  input  logic       dn_done_i,
  input  logic       up_elapsed_i,
  input  logic       dn_elapsed_i,
  output seq_state_e state_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:    if (go_i)         st_d = S_PA_ON;
      S_PA_ON:                     st_d = S_RAMP_UP;
      S_RAMP_UP: if (up_done_i)    st_d = S_HOLD_UP;
      S_HOLD_UP: if (up_elapsed_i) st_d = S_ACTIVE;
      S_ACTIVE:  if (!go_i)        st_d = S_RAMP_DN;
      S_RAMP_DN: if (dn_done_i)    st_d = S_HOLD_DN;
      S_HOLD_DN: if (dn_elapsed_i) st_d = S_IDLE;
      default:                     st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/tx_ramp_seq.sv
module tx_ramp_seq
  import tx_ramp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             tick_fast_i,
  input  logic             tick_slow_i,
  input  logic             ramp_up_done_i,
  input  logic             ramp_dn_done_i,
  input  logic [CNT_W-1:0] hold_up_i,
  input  logic [CNT_W-1:0] hold_dn_i,
  output logic             pa_en_o,
  output logic             ramp_up_req_o,
  output logic             ramp_dn_req_o,
  output logic             busy_o
);
  logic             rst_sync_n;
  seq_state_e       st_q;
  logic [CNT_W-1:0] up_cnt, dn_cnt;
  logic             up_elapsed, dn_elapsed;
  logic             up_clr, up_inc, dn_clr, dn_inc;

  tx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  // Rising hold is timed from the start of the rising ramp.
  assign up_clr = (st_q == S_PA_ON);
  assign up_inc = tick_slow_i && ((st_q == S_RAMP_UP) || (st_q == S_HOLD_UP));
  // Falling hold is timed from the end of the falling ramp.
  assign dn_clr = (st_q == S_RAMP_DN);
  assign dn_inc = tick_fast_i && (st_q == S_HOLD_DN);

  tx_hold_timer #(.CNT_W(CNT_W)) u_up_tmr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (up_clr),
    .inc_i     (up_inc),
    .limit_i   (hold_up_i),
    .cnt_o     (up_cnt),
    .elapsed_o (up_elapsed)
  );

  tx_hold_timer #(.CNT_W(CNT_W)) u_dn_tmr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (dn_clr),
    .inc_i     (dn_inc),
    .limit_i   (hold_dn_i),
    .cnt_o     (dn_cnt),
    .elapsed_o (dn_elapsed)
  );

  tx_ramp_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .go_i         (go_i),
    .up_done_i    (ramp_up_done_i),
    .dn_done_i    (ramp_dn_done_i),
    .up_elapsed_i (up_elapsed),
    .dn_elapsed_i (dn_elapsed),
    .state_o      (st_q)
  );

  assign pa_en_o       = (st_q != S_IDLE);
  assign busy_o        = (st_q != S_IDLE);
  assign ramp_up_req_o = (st_q == S_RAMP_UP);
  assign ramp_dn_req_o = (st_q == S_RAMP_DN);
endmodule

// File: rtl/tx_ramp_seq_chk.sv
module tx_ramp_seq_chk
  import tx_ramp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             go_i,
  input logic             ramp_up_done_i,
  input logic             ramp_dn_done_i,
  input logic [CNT_W-1:0] hold_up_i,
  input logic [CNT_W-1:0] hold_dn_i,
  input seq_state_e       st_q,
  input logic [CNT_W-1:0] up_cnt,
  input logic [CNT_W-1:0] dn_cnt,
  input logic             pa_en_o,
  input logic             ramp_up_req_o,
  input logic             ramp_dn_req_o,
  input logic             busy_o
);
  a_r2_go_launch: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == S_IDLE && go_i) |=> (pa_en_o && !ramp_up_req_o));

  a_r3_up_req_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ramp_up_req_o && !ramp_up_done_i) |=> ramp_up_req_o);

  a_r4_hold_wait: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == S_HOLD_UP && up_cnt < hold_up_i) |=> (st_q == S_HOLD_UP));

  a_r5_zero_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == S_HOLD_UP && hold_up_i == '0) |=> (st_q == S_ACTIVE));

  a_r6_go_drop: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == S_ACTIVE && !go_i) |=> ramp_dn_req_o);

  a_r7_dn_req_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ramp_dn_req_o && !ramp_dn_done_i) |=> ramp_dn_req_o);

  a_r7_pa_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == S_HOLD_DN && dn_cnt < hold_dn_i) |=> pa_en_o);

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q != S_IDLE) |=> (st_q != S_PA_ON));

  a_r9_one_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({ramp_up_req_o, ramp_dn_req_o}));

  a_r9_req_busy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ramp_up_req_o || ramp_dn_req_o) |-> busy_o);
endmodule

bind tx_ramp_seq tx_ramp_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .go_i           (go_i),
  .ramp_up_done_i (ramp_up_done_i),
  .ramp_dn_done_i (ramp_dn_done_i),
  .hold_up_i      (hold_up_i),
  .hold_dn_i      (hold_dn_i),
  .st_q           (st_q),
  .up_cnt         (up_cnt),
  .dn_cnt         (dn_cnt),
  .pa_en_o        (pa_en_o),
  .ramp_up_req_o  (ramp_up_req_o),
  .ramp_dn_req_o  (ramp_dn_req_o),
  .busy_o         (busy_o)
);

// File: tb/sim_tx_ramp_seq.sv
`timescale 1ns/1ps
module sim_tx_ramp_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go_i = 1'b0;
  logic        tick_fast_i = 1'b0;
  logic        tick_slow_i = 1'b0;
  logic        ramp_up_done_i = 1'b0;
  logic        ramp_dn_done_i = 1'b0;
  logic [15:0] hold_up_i = '0;
  logic [15:0] hold_dn_i = '0;
  logic        pa_en_o, ramp_up_req_o, ramp_dn_req_o, busy_o;

  always #10 clk = ~clk;

  tx_ramp_seq u0 (
    .clk, .rst_n, .go_i, .tick_fast_i, .tick_slow_i,
    .ramp_up_done_i, .ramp_dn_done_i, .hold_up_i, .hold_dn_i,
    .pa_en_o, .ramp_up_req_o, .ramp_dn_req_o, .busy_o
  );

  int    checks = 0;
  int    errors = 0;
  string cur = "R1";
  bit    finished = 1'b0;

  // stimulus knobs
  int fast_n = 1, slow_n = 1, up_len = 1, dn_len = 1, cyc = 0;
  int upc = 0, dnc = 0;
  bit stray = 1'b0;

  // behavioural model: 0 rest,1 amp on,2 rising,3 rising hold,4 active,5 falling,6 falling hold
  int mst = 0, mup = 0, mdn = 0, rcnt = 0;

  always @(posedge clk) begin
    int nst, nup, ndn;
    if (!rst_n) begin
      rcnt = 0; mst = 0; mup = 0; mdn = 0;
    end else if (rcnt < 2) begin
      mst = 0; mup = 0; mdn = 0; rcnt = rcnt + 1;
    end else begin
      nst = mst; nup = mup; ndn = mdn;
      case (mst)
        0: if (go_i) nst = 1;
        1: begin nst = 2; nup = 0; end
        2, 3: begin
          if (mst == 2 && ramp_up_done_i) nst = 3;
          if (mst == 3 && mup >= int'(hold_up_i)) nst = 4;
          if (tick_slow_i && mup < 65535) nup = mup + 1;
        end
        4: if (!go_i) nst = 5;
        5: begin ndn = 0; if (ramp_dn_done_i) nst = 6; end
        6: begin
          if (mdn >= int'(hold_dn_i)) nst = 0;
          if (tick_fast_i && mdn < 65535) ndn = mdn + 1;
        end
        default: nst = 0;
      endcase
      mst = nst; mup = nup; mdn = ndn;
    end
  end

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b at %0t", cur, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    chk(pa_en_o,       mst != 0, "R7 pa_en_o");
    chk(ramp_up_req_o, mst == 2, "R3 ramp_up_req_o");
    chk(ramp_dn_req_o, mst == 5, "R7 ramp_dn_req_o");
    chk(busy_o,        mst != 0, "R9 busy_o");
  end

  // time-base enables and ramp generator responder
  always @(negedge clk) begin
    cyc = cyc + 1;
    tick_fast_i = (cyc % fast_n) == 0;
    tick_slow_i = (cyc % slow_n) == 0;
    upc = ramp_up_req_o ? upc + 1 : 0;
    dnc = ramp_dn_req_o ? dnc + 1 : 0;
    ramp_up_done_i = (ramp_up_req_o && upc >= up_len) || (stray && (cyc % 3) == 0);
    ramp_dn_done_i = (ramp_dn_req_o && dnc >= dn_len) || (stray && (cyc % 5) == 1);
  end

  task automatic wait_state(input int s);
    while (mst != s) @(negedge clk);
  endtask

  task automatic burst(input int hu, input int hd, input int ul, input int dl,
                       input int fn, input int sn, input int act, input string tag);
    hold_up_i = 16'(hu); hold_dn_i = 16'(hd);
    up_len = ul; dn_len = dl; fast_n = fn; slow_n = sn; cur = tag;
    go_i = 1'b1;
    wait_state(4);
    repeat (act) @(negedge clk);
    go_i = 1'b0;
    wait_state(0);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in %s", cur);
    finish_run();
  end

  initial begin
    // R1: reset state, including the synchroniser cycles
    repeat (3) @(negedge clk);
    chk(busy_o, 1'b0, "R1 busy in reset");
    go_i = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(pa_en_o, 1'b0, "R1 pa_en during sync release");
    go_i = 1'b0;
    repeat (3) @(negedge clk);

    // R2, R4, R6 directed
    cur = "R2";
    hold_up_i = 16'd5; hold_dn_i = 16'd3; up_len = 2; dn_len = 2;
    go_i = 1'b1;
    @(negedge clk);
    chk(pa_en_o, 1'b1, "R2 pa_en after go");
    chk(ramp_up_req_o, 1'b0, "R2 no ramp yet");
    @(negedge clk);
    chk(ramp_up_req_o, 1'b1, "R2 ramp request");
    cur = "R4";
    wait_state(4);
    repeat (3) @(negedge clk);
    cur = "R6";
    chk(ramp_dn_req_o, 1'b0, "R6 active while go high");
    go_i = 1'b0;
    @(negedge clk);
    chk(ramp_dn_req_o, 1'b1, "R6 ramp-down after go low");
    wait_state(0);
    repeat (2) @(negedge clk);

    burst(0, 0, 1, 1, 1, 1, 2, "R5");
    burst(4, 7, 20, 3, 1, 4, 1, "R4");   // ramp outlasts the rising hold
    burst(3, 300, 2, 2, 1, 1, 5, "R7");
    burst(9, 6, 4, 4, 2, 3, 3, "R7");

    // R8: go dropped in rising hold, raised again in falling hold
    cur = "R8";
    hold_up_i = 16'd10; hold_dn_i = 16'd12; up_len = 2; dn_len = 2;
    fast_n = 1; slow_n = 1;
    go_i = 1'b1;
    wait_state(3);
    go_i = 1'b0;
    wait_state(6);
    go_i = 1'b1;
    @(negedge clk);
    chk(ramp_up_req_o, 1'b0, "R8 go ignored in hold");
    wait_state(0);
    wait_state(4);
    go_i = 1'b0;
    wait_state(0);
    repeat (2) @(negedge clk);

    // R10: stray done pulses in every state
    stray = 1'b1;
    cur = "R10";
    repeat (6) @(negedge clk);
    chk(busy_o, 1'b0, "R10 stray done at rest");
    burst(6, 5, 3, 3, 2, 3, 4, "R10");
    burst(2, 40, 8, 8, 3, 2, 6, "R10");
    stray = 1'b0;
    repeat (4) @(negedge clk);

    finish_run();
  end
endmodule